// File: doc/BRIEF.md
# Up/Down PWM Timer with Prescaler

This block is a 16-bit timer that counts from zero up to a programmable reload value and back down again, and drives one PWM output from the count. A compare value and a 2-bit mode field set the shape of the waveform. In set mode the output is high for the whole downward half of the period. In clear mode it is low for the whole downward half. Both of these give a duty resolution of one part in twice the reload value. In toggle mode the output inverts each time the count passes the compare value, and the starting pin level decides which part of the period is high.

The count advances on ticks. A tick comes either from a prescaled system clock, with a 3-bit power-of-four divider, or from falling edges of an external input pin, which is first passed through a two-flop synchronizer. A small register port gives access to the control word, the reload value, the compare value and the live count. Clearing the run bit freezes the count and the output.

Top module: `updown_pwm_timer`

## Requirements
- R1: After reset every register (control, reload, compare, count) reads 0 and `pwm_out` is 0. Control bits 15:8 always read as 0, whatever value was written to them.
- R2: Register map: address 0 is control, 1 is reload, 2 is compare, 3 is count. Control bit 0 is run. Bits 3:1 select the prescale code. Bits 5:4 select the mode (00 set, 01 clear, 10 and 11 toggle). Bit 6 selects external counting. Bit 7 is the pin load level. Timer mode prescale code k (0 to 5) gives one tick every 4^k clocks. Codes 6 and 7 give one tick per clock. The prescaler restarts from zero whenever run is 0.
- R3: On each tick the count steps by one: up from 0 to the reload value R, then down to 0. The direction turns at both ends, so the sequence repeats every 2R ticks (0,1,..,R,R-1,..,1,0,..).
- R4: In set mode, after each tick the output is high when the count is in its downward half or is below compare. Over one period this gives (R + C) high ticks out of 2R.
- R5: In clear mode, after each tick the output is high only in the upward half while the count is below compare. This gives C high ticks out of 2R, and the output is never high in the downward half.
- R6: In toggle mode the output inverts on every tick whose new count equals compare. With 0 < C < R, a high start level gives 2C high ticks per 2R, and a low start level gives 2(R − C).
- R7: With bit 6 set, the count advances once for each falling edge of `ext_pin`, seen after a two-flop synchronizer. Rising edges and steady levels do not advance it.
- R8: While run is 0, the count and `pwm_out` hold their values.
- R9: Writing the count register loads the count and sets the direction to upward. A control write that keeps run at 0, made while run is already 0, loads `pwm_out` from bit 7.
- R10: With a reload value of 0 the count stays at 0 on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| ext_pin | input | 1 | External count input, asynchronous |
| pwm_out | output | 1 | PWM output |

## Verification
Embedded properties check every cycle that the count moves by exactly one per tick and holds without one, that a zero reload pins it at zero, that the set and clear modes force the output level in the downward half, and that external falling edges never produce back-to-back ticks. Only the bench scenarios can show the exact up/down count sequence, the tick rate for each prescale code, the duty totals over a full period in each mode, and the dependence of toggle duty on the start level. The bench also drives the synchronizer latency with pulsed input and checks frozen state across a stopped interval.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;

    // highest prescale code with its own divider; 4^k needs 2k counter bits
    localparam int unsigned PSEL_MAX = 5;
    localparam int unsigned PRESC_W  = 2 * PSEL_MAX;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_RLD  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;

    typedef enum logic [1:0] {
        MODE_SET  = 2'b00,
        MODE_CLR  = 2'b01,
        MODE_TGL  = 2'b10,
        MODE_TGLB = 2'b11
    } pwm_mode_e;

    // packed MSB first: bit 7 pin_lvl ... bit 0 run
    typedef struct packed {
        logic      pin_lvl;
        logic      ext_sel;
        pwm_mode_e mode;
        logic [2:0] psel;
        logic      run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_tmr_regs.sv
`timescale 1ns/1ps
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic [DATA_W-1:0] count_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] compare_o,
    output logic              cnt_ld_o,
    output logic [DATA_W-1:0] cnt_ld_val_o,
    output logic              pin_ld_o,
    output logic              pin_ld_val_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned PAD_W = DATA_W - CTRL_W;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] compare;
    } regs_t;

    regs_t regs_d, regs_q;
    ctrl_t wr_ctrl;

    always_comb begin
        wr_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        regs_d  = regs_q;
        if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: regs_d.ctrl    = wr_ctrl;
                ADDR_RLD:  regs_d.reload  = wr_data;
                ADDR_CMP:  regs_d.compare = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl_o       = regs_q.ctrl;
    assign reload_o     = regs_q.reload;
    assign compare_o    = regs_q.compare;
    assign cnt_ld_o     = wr_en && (wr_addr == ADDR_CNT);
    assign cnt_ld_val_o = wr_data;
    assign pin_ld_o     = wr_en && (wr_addr == ADDR_CTRL) && !regs_q.ctrl.run && !wr_ctrl.run;
    assign pin_ld_val_o = wr_ctrl.pin_lvl;

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data_o = {{PAD_W{1'b0}}, regs_q.ctrl};
            ADDR_RLD:  rd_data_o = regs_q.reload;
            ADDR_CMP:  rd_data_o = regs_q.compare;
            default:   rd_data_o = count_i;
        endcase
    end

    // R9: the run bit can only move through a control write
    run_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_CTRL) |=> $stable(ctrl_o.run));

endmodule

// File: rtl/pwm_tmr_tick.sv
`timescale 1ns/1ps
module pwm_tmr_tick
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       ext_sel_i,
    input  logic [2:0] psel_i,
    input  logic       ext_pin_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [PRESC_W-1:0]     presc;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [PRESC_W-1:0] term;
    logic               fall;
    logic               presc_hit;

    // 4^k - 1 for codes up to PSEL_MAX, zero (divide by one) above
    always_comb begin
        if (psel_i <= 3'(PSEL_MAX))
            term = (PRESC_W'(1) << {psel_i, 1'b0}) - PRESC_W'(1);
        else
            term = '0;
    end

    assign fall      = st_q.prev && !st_q.sync[SYNC_STAGES-1];
    assign presc_hit = (st_q.presc == term);

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ext_pin_i};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        if (!run_i || ext_sel_i || presc_hit)
            st_d.presc = '0;
        else
            st_d.presc = st_q.presc + PRESC_W'(1);
        tick_o = run_i && (ext_sel_i ? fall : presc_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: one falling edge yields exactly one tick
    ext_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && ext_sel_i) |=> (!tick_o || !ext_sel_i));

    // R2: a divider above one never ticks on two cycles in a row
    presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !ext_sel_i && psel_i != 3'd0 && psel_i <= 3'(PSEL_MAX))
        |=> (!tick_o || ext_sel_i || !$stable(psel_i)));

    // R8: a stopped timer produces no ticks
    no_tick_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);

endmodule

// File: rtl/pwm_tmr_core.sv
`timescale 1ns/1ps
module pwm_tmr_core
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  pwm_mode_e         mode_i,
    input  logic [DATA_W-1:0] reload_i,
    input  logic [DATA_W-1:0] compare_i,
    input  logic              cnt_ld_i,
    input  logic [DATA_W-1:0] cnt_ld_val_i,
    input  logic              pin_ld_i,
    input  logic              pin_ld_val_i,
    output logic [DATA_W-1:0] count_o,
    output logic              pwm_o
);

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic              down;
        logic              out;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cnt_ld_i) begin
            st_d.count = cnt_ld_val_i;
            st_d.down  = 1'b0;
        end else if (tick_i) begin
            if (reload_i == '0) begin
                st_d.count = '0;
                st_d.down  = 1'b0;
            end else if ((!st_q.down && st_q.count < reload_i) || st_q.count == '0) begin
                st_d.count = st_q.count + DATA_W'(1);
                st_d.down  = (st_d.count >= reload_i);
            end else begin
                st_d.count = st_q.count - DATA_W'(1);
                st_d.down  = (st_d.count != '0);
            end
        end

        if (pin_ld_i) begin
            st_d.out = pin_ld_val_i;
        end else if (tick_i && !cnt_ld_i) begin
            unique case (mode_i)
                MODE_SET: st_d.out = st_d.down || (st_d.count < compare_i);
                MODE_CLR: st_d.out = !st_d.down && (st_d.count < compare_i);
                default:  st_d.out = st_q.out ^ (st_d.count == compare_i);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign pwm_o   = st_q.out;

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_ld_i && reload_i != '0)
        |=> (count_o == $past(count_o) + DATA_W'(1)) || (count_o == $past(count_o) - DATA_W'(1)));

    // R8
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_ld_i) |=> $stable(count_o));

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !pin_ld_i) |=> $stable(pwm_o));

    // R4
    set_down_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_ld_i && !pin_ld_i && mode_i == MODE_SET) |=> (!st_q.down || pwm_o));

    // R5
    clr_down_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_ld_i && !pin_ld_i && mode_i == MODE_CLR) |=> (!st_q.down || !pwm_o));

    // R10
    zero_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !cnt_ld_i && reload_i == '0) |=> (count_o == '0));

endmodule

// File: rtl/updown_pwm_timer.sv
`timescale 1ns/1ps
module updown_pwm_timer
    import pwm_tmr_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_pin,
    output logic              pwm_out
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] compare;
    logic              cnt_ld;
    logic [DATA_W-1:0] cnt_ld_val;
    logic              pin_ld;
    logic              pin_ld_val;
    logic [DATA_W-1:0] count;
    logic              tick;

    pwm_tmr_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .count_i      (count),
        .ctrl_o       (ctrl),
        .reload_o     (reload),
        .compare_o    (compare),
        .cnt_ld_o     (cnt_ld),
        .cnt_ld_val_o (cnt_ld_val),
        .pin_ld_o     (pin_ld),
        .pin_ld_val_o (pin_ld_val),
        .rd_data_o    (rd_data)
    );

    pwm_tmr_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .ext_sel_i (ctrl.ext_sel),
        .psel_i    (ctrl.psel),
        .ext_pin_i (ext_pin),
        .tick_o    (tick)
    );

    pwm_tmr_core #(.DATA_W(DATA_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .mode_i       (ctrl.mode),
        .reload_i     (reload),
        .compare_i    (compare),
        .cnt_ld_i     (cnt_ld),
        .cnt_ld_val_i (cnt_ld_val),
        .pin_ld_i     (pin_ld),
        .pin_ld_val_i (pin_ld_val),
        .count_o      (count),
        .pwm_o        (pwm_out)
    );

endmodule

// File: tb/test_updown_pwm_timer.sv
`timescale 1ns/1ps
module test_updown_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ext_pin = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        int    kind;   // 0 pwm_out, 1 rd_data, 2 measured value
        int    exp;
        int    got;
    } item_t;

    item_t sbq[$];

    always #2 clk = ~clk;

    updown_pwm_timer i_updown_pwm_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ext_pin (ext_pin),
        .pwm_out (pwm_out)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t it;
                int act;
                it = sbq.pop_front();
                case (it.kind)
                    0:       act = int'(pwm_out);
                    1:       act = int'(rd_data);
                    default: act = it.got;
                endcase
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%0d expected=%0d", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic push(input string req, input int kind, input int exp, input int got = 0);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp; it.got = got;
        sbq.push_back(it);
    endtask

    task automatic rd_chk(input logic [1:0] a, input string req, input int exp);
        rd_addr = a;
        push(req, 1, exp);
        @(negedge clk); #1;
    endtask

    task automatic out_chk(input string req, input int exp);
        push(req, 0, exp);
        @(negedge clk); #1;
    endtask

    // the write takes effect at the next rising edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] mk_ctrl(input bit run, input int psel, input int mode,
                                            input bit ext, input bit lvl);
        return {8'h00, lvl, ext, 2'(mode), 3'(psel), run};
    endfunction

    task automatic measure(input int skip, input int n, output int high);
        high = 0;
        repeat (skip) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) high++;
        end
        #1;
    endtask

    task automatic pwm_case(input string req, input int mode, input bit lvl, input int exp);
        int h;
        wr(2'd0, mk_ctrl(0, 0, mode, 0, 0));
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd0);
        wr(2'd0, mk_ctrl(0, 0, mode, 0, lvl));
        wr(2'd0, mk_ctrl(1, 0, mode, 0, lvl));
        measure(20, 20, h);
        push(req, 2, exp, h);
        wr(2'd0, mk_ctrl(0, 0, mode, 0, lvl));
    endtask

    initial begin
        int seq [9] = '{1, 2, 3, 4, 3, 2, 1, 0, 1};
        int pexp [8] = '{1100, 275, 68, 17, 4, 1, 1100, 1100};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        rd_chk(2'd0, "R1 ctrl after reset", 0);
        rd_chk(2'd1, "R1 reload after reset", 0);
        rd_chk(2'd2, "R1 compare after reset", 0);
        rd_chk(2'd3, "R1 count after reset", 0);
        out_chk("R1 pwm_out after reset", 0);
        wr(2'd0, 16'hFF00);
        rd_chk(2'd0, "R1 reserved control bits", 0);

        // R3 up/down sequence with reload 4, divide by one
        wr(2'd1, 16'd4);
        rd_addr = 2'd3;
        wr(2'd0, mk_ctrl(1, 0, 0, 0, 0));
        push("R3 count before first tick", 1, 0);
        for (int j = 0; j < 9; j++) begin
            @(posedge clk); #1;
            push($sformatf("R3 count step %0d", j + 1), 1, seq[j]);
        end
        @(negedge clk); #1;
        wr(2'd0, mk_ctrl(0, 0, 0, 0, 0));

        // R2 prescale codes over 1100 clocks, reload 2000
        wr(2'd1, 16'd2000);
        for (int k = 0; k < 8; k++) begin
            wr(2'd3, 16'd0);
            wr(2'd0, mk_ctrl(1, k, 0, 0, 0));
            repeat (1099) @(posedge clk);
            #1;
            wr(2'd0, mk_ctrl(0, k, 0, 0, 0));
            rd_chk(2'd3, $sformatf("R2 ticks for code %0d", k), pexp[k]);
        end

        // R9 count write
        wr(2'd3, 16'd7);
        rd_chk(2'd3, "R9 count write loads value", 7);

        // R7 external falling edges
        wr(2'd3, 16'd0);
        wr(2'd0, mk_ctrl(1, 3, 0, 1, 0));
        for (int p = 0; p < 5; p++) begin
            ext_pin = 1'b1;
            repeat (4) @(posedge clk);
            #1 ext_pin = 1'b0;
            repeat (4) @(posedge clk);
            #1;
        end
        repeat (4) @(posedge clk);
        #1;
        rd_chk(2'd3, "R7 five falling edges counted", 5);
        ext_pin = 1'b1;
        repeat (8) @(posedge clk);
        #1;
        rd_chk(2'd3, "R7 rising edge ignored", 5);
        wr(2'd0, mk_ctrl(0, 0, 0, 0, 0));
        ext_pin = 1'b0;

        // R9 pin level load while stopped
        wr(2'd0, mk_ctrl(0, 0, 2, 0, 1));
        out_chk("R9 pin load level 1", 1);
        wr(2'd0, mk_ctrl(0, 0, 2, 0, 0));
        out_chk("R9 pin load level 0", 0);

        // R4 R5 R6 duty totals, reload 10, compare 3, 20 ticks per period
        pwm_case("R4 set mode high ticks", 0, 0, 13);
        pwm_case("R5 clear mode high ticks", 1, 0, 3);
        pwm_case("R6 toggle from high start", 2, 1, 6);
        pwm_case("R6 toggle from low start", 2, 0, 14);

        // R8 freeze: 12 ticks in set mode leave count 8 on the way down, out high
        wr(2'd0, mk_ctrl(0, 0, 0, 0, 0));
        wr(2'd1, 16'd10);
        wr(2'd2, 16'd3);
        wr(2'd3, 16'd0);
        wr(2'd0, mk_ctrl(1, 0, 0, 0, 0));
        repeat (11) @(posedge clk);
        #1;
        wr(2'd0, mk_ctrl(0, 0, 0, 0, 0));
        rd_chk(2'd3, "R8 count at stop", 8);
        out_chk("R8 out at stop", 1);
        repeat (10) @(posedge clk);
        #1;
        rd_chk(2'd3, "R8 count held while stopped", 8);
        out_chk("R8 out held while stopped", 1);

        // R10 zero reload
        wr(2'd1, 16'd0);
        wr(2'd3, 16'd0);
        wr(2'd0, mk_ctrl(1, 0, 0, 0, 0));
        repeat (20) @(posedge clk);
        #1;
        rd_chk(2'd3, "R10 count pinned at zero", 0);
        wr(2'd0, mk_ctrl(0, 0, 0, 0, 0));

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule